// File: doc/BRIEF.md
# Translation Fault Status and Address Capture

This block records faults reported by an I/O address translation unit and tells the processor about them with a level interrupt. When the translator signals a fault, it passes the faulting address and says whether the access was a read. The block then loads a 32-bit status word and a page-aligned fault address, and it raises the interrupt. Software reads and writes these two registers through strobes from the register bank. Every software read or write of either register drops the interrupt.

The interrupt is driven by a two-state machine. In `IRQ_QUIET` the interrupt is low. A fault pulse takes the machine to `IRQ_ALERT`. Any software access to either register that comes without a fault in the same cycle takes it back to `IRQ_QUIET`. In `IRQ_ALERT`, a further fault keeps the machine in that state. In `IRQ_QUIET`, an access with no fault keeps it there.

If a fault arrives while the error flag from an earlier fault is still set, the block marks a multiple-error condition and keeps the first address. If a fault and a software access land in the same cycle, the fault capture takes priority.

Top module: `fault_status_reporter`

## Requirements
- R1: After reset the status word is 0x00800000, the address register is 0 and the interrupt is low.
- R2: A fault pulse while status bit 31 is clear loads status 0xC0820000 (bits 31, 30, 23 and 17) and loads the fault address with its low 12 bits forced to zero. One cycle later the interrupt is high.
- R3: If that first fault is a read, status bit 18 is also set, so the status word is 0xC0860000.
- R4: A fault pulse while status bit 31 is set ORs in bit 19 and leaves every other status bit and the address register unchanged. The interrupt is high on the next cycle.
- R5: A software write to the status register stores (data AND 0xFF0FFFFF) OR 0x00800000 and drops the interrupt.
- R6: A software write to the address register stores the data unchanged and drops the interrupt.
- R7: A software read of either register returns its current contents, leaves both registers unchanged and drops the interrupt.
- R8: When a fault pulse and a software access fall in the same cycle, the fault update is applied, any write data is discarded and the interrupt is high on the next cycle.
- R9: The interrupt rises only in the cycle after a fault pulse. Software accesses never raise it.
- R10: Status bit 23 reads as 1 at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_valid | input | 1 | Single-cycle fault pulse from the translator |
| flt_read | input | 1 | The faulting access was a read |
| flt_addr | input | ADDR_W | Faulting address |
| sw_stat_wr | input | 1 | Software write strobe, status register |
| sw_stat_rd | input | 1 | Software read strobe, status register |
| sw_addr_wr | input | 1 | Software write strobe, address register |
| sw_addr_rd | input | 1 | Software read strobe, address register |
| sw_wdata | input | DATA_W | Software write data |
| stat_value | output | DATA_W | Current status register contents |
| addr_value | output | ADDR_W | Current fault address contents |
| irq | output | 1 | Level interrupt to the processor |

## Verification
The assertions assume that `flt_valid` is a clean registered pulse. They also assume that the register bank raises at most one software strobe per cycle, because a real decoder cannot select both offsets at once. The stimulus only ever drives one strobe in a cycle. Fault pulses are allowed to coincide with any single strobe, so the priority rule is covered. The bench holds every input for exactly one cycle and then returns it to idle. Every property therefore looks at a single-cycle antecedent.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int STAT_W = 32;

    localparam logic [STAT_W-1:0] ST_ERR      = 32'h8000_0000;
    localparam logic [STAT_W-1:0] ST_LATE     = 32'h4000_0000;
    localparam logic [STAT_W-1:0] ST_RSVD     = 32'h0080_0000;
    localparam logic [STAT_W-1:0] ST_MULTI    = 32'h0008_0000;
    localparam logic [STAT_W-1:0] ST_RD       = 32'h0004_0000;
    localparam logic [STAT_W-1:0] ST_ADDR_OK  = 32'h0002_0000;
    localparam logic [STAT_W-1:0] ST_KEEP     = 32'hFF0F_FFFF;
    localparam int                ERR_BIT     = 31;

    typedef enum logic {
        IRQ_QUIET = 1'b0,
        IRQ_ALERT = 1'b1
    } irq_state_e;
endpackage

// File: rtl/fsr_irq_fsm.sv
module fsr_irq_fsm
    import fsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    input  logic access,
    output logic irq
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET: if (fault)       state_d = IRQ_ALERT;
            IRQ_ALERT: if (!fault && access) state_d = IRQ_QUIET;
            default:                    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_ALERT);
    end
endmodule

// File: rtl/fsr_stat_reg.sv
module fsr_stat_reg
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  logic              fault_read,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] stat,
    output logic              first_fault
);
    logic [STAT_W-1:0] stat_q, stat_d;

    assign first_fault = fault && !stat_q[ERR_BIT];

    always_comb begin
        stat_d = stat_q;
        if (fault) begin
            if (stat_q[ERR_BIT])
                stat_d = stat_q | ST_MULTI;
            else
                stat_d = ST_ERR | ST_LATE | ST_RSVD | ST_ADDR_OK
                       | (fault_read ? ST_RD : '0);
        end else if (wr) begin
            stat_d = (wdata & ST_KEEP) | ST_RSVD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= ST_RSVD;
        else        stat_q <= stat_d;
    end

    assign stat = stat_q;
endmodule

// File: rtl/fsr_addr_reg.sv
module fsr_addr_reg #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_fault,
    input  logic              fault,
    input  logic [ADDR_W-1:0] fault_addr,
    input  logic              wr,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1));

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            addr_q <= '0;
        else if (load_fault)   addr_q <= fault_addr & PAGE_MASK;
        else if (wr && !fault) addr_q <= wdata;
    end

    assign addr = addr_q;
endmodule

// File: rtl/fault_status_reporter.sv
module fault_status_reporter
    import fsr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_valid,
    input  logic              flt_read,
    input  logic [ADDR_W-1:0] flt_addr,
    input  logic              sw_stat_wr,
    input  logic              sw_stat_rd,
    input  logic              sw_addr_wr,
    input  logic              sw_addr_rd,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] stat_value,
    output logic [ADDR_W-1:0] addr_value,
    output logic              irq
);
    logic any_access;
    logic first_fault;
    logic [STAT_W-1:0] stat_w;

    assign any_access = sw_stat_wr | sw_stat_rd | sw_addr_wr | sw_addr_rd;

    fsr_irq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .fault  (flt_valid),
        .access (any_access),
        .irq    (irq)
    );

    fsr_stat_reg u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault       (flt_valid),
        .fault_read  (flt_read),
        .wr          (sw_stat_wr),
        .wdata       (STAT_W'(sw_wdata)),
        .stat        (stat_w),
        .first_fault (first_fault)
    );

    fsr_addr_reg #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_fault (first_fault),
        .fault      (flt_valid),
        .fault_addr (flt_addr),
        .wr         (sw_addr_wr),
        .wdata      (ADDR_W'(sw_wdata)),
        .addr       (addr_value)
    );

    assign stat_value = DATA_W'(stat_w);
endmodule

// File: rtl/fault_status_reporter_chk.sv
module fault_status_reporter_chk #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flt_valid,
    input logic              flt_read,
    input logic [ADDR_W-1:0] flt_addr,
    input logic              sw_stat_wr,
    input logic              sw_stat_rd,
    input logic              sw_addr_wr,
    input logic              sw_addr_rd,
    input logic [DATA_W-1:0] sw_wdata,
    input logic [DATA_W-1:0] stat_value,
    input logic [ADDR_W-1:0] addr_value,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] LOW_BITS = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);
    logic acc;
    assign acc = sw_stat_wr | sw_stat_rd | sw_addr_wr | sw_addr_rd;

    assert_rsvd_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_value[23]);

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(flt_valid));

    assert_fault_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> irq);

    assert_first_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !stat_value[31]) |=> stat_value[31] && stat_value[17]
                                         && ((addr_value & LOW_BITS) == '0));

    assert_read_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !stat_value[31] && flt_read) |=> stat_value[18]);

    assert_multi_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && stat_value[31]) |=> stat_value[19] && $stable(addr_value));

    assert_stat_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stat_wr && !flt_valid) |=>
            stat_value == (($past(sw_wdata) & 32'hFF0F_FFFF) | 32'h0080_0000));

    assert_addr_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_addr_wr && !flt_valid) |=> addr_value == ADDR_W'($past(sw_wdata)));

    assert_access_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !flt_valid) |=> !irq);

    assert_read_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_stat_rd || sw_addr_rd) && !flt_valid) |=>
            $stable(stat_value) && $stable(addr_value));

    assert_fault_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && sw_stat_wr) |=> stat_value[31] && irq);
endmodule

bind fault_status_reporter fault_status_reporter_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flt_valid  (flt_valid),
    .flt_read   (flt_read),
    .flt_addr   (flt_addr),
    .sw_stat_wr (sw_stat_wr),
    .sw_stat_rd (sw_stat_rd),
    .sw_addr_wr (sw_addr_wr),
    .sw_addr_rd (sw_addr_rd),
    .sw_wdata   (sw_wdata),
    .stat_value (stat_value),
    .addr_value (addr_value),
    .irq        (irq)
);

// File: tb/fault_status_reporter_tb_top.sv
`timescale 1ns/1ps
module fault_status_reporter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flt_valid = 1'b0, flt_read = 1'b0;
    logic [31:0] flt_addr = '0;
    logic        sw_stat_wr = 1'b0, sw_stat_rd = 1'b0, sw_addr_wr = 1'b0, sw_addr_rd = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] stat_value, addr_value;
    logic        irq;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    logic [31:0] m_stat, m_addr;
    logic        m_irq;

    always #2 clk = ~clk;

    fault_status_reporter dut_i (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_read(flt_read),
        .flt_addr(flt_addr), .sw_stat_wr(sw_stat_wr), .sw_stat_rd(sw_stat_rd),
        .sw_addr_wr(sw_addr_wr), .sw_addr_rd(sw_addr_rd), .sw_wdata(sw_wdata),
        .stat_value(stat_value), .addr_value(addr_value), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " stat"}, stat_value, m_stat);
        check({tag, " addr"}, addr_value, m_addr);
        check({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq});
        check({tag, " R10 rsvd"}, {31'b0, stat_value[23]}, 32'd1);
    endtask

    // kind: 0 none, 1 stat write, 2 stat read, 3 addr write, 4 addr read
    task automatic step(input string tag, input bit flt, input bit rd,
                        input logic [31:0] fa, input int kind, input logic [31:0] wd);
        @(negedge clk);
        flt_valid = flt; flt_read = rd; flt_addr = fa; sw_wdata = wd;
        sw_stat_wr = (kind == 1); sw_stat_rd = (kind == 2);
        sw_addr_wr = (kind == 3); sw_addr_rd = (kind == 4);
        if (flt) begin
            if (m_stat[31]) m_stat = m_stat | 32'h0008_0000;
            else begin
                m_stat = 32'hC082_0000 | (rd ? 32'h0004_0000 : 32'h0);
                m_addr = {fa[31:12], 12'h000};
            end
            m_irq = 1'b1;
        end else if (kind != 0) begin
            if (kind == 1) m_stat = (wd & 32'hFF0F_FFFF) | 32'h0080_0000;
            if (kind == 3) m_addr = wd;
            m_irq = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        flt_valid = 1'b0; flt_read = 1'b0; sw_stat_wr = 1'b0; sw_stat_rd = 1'b0;
        sw_addr_wr = 1'b0; sw_addr_rd = 1'b0;
        check_all(tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        m_stat = 32'h0080_0000; m_addr = '0; m_irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;

        // R2 R3 R4 R7: sweep direction and address, then a second fault and reads
        for (int d = 0; d < 2; d++) begin
            for (int a = 0; a < 6; a++) begin
                logic [31:0] fa;
                fa = (32'h1357_9BDF * (a + 1)) ^ (32'h0000_0FFF >> a);
                step("R5 clear", 1'b0, 1'b0, '0, 1, 32'h0);
                step(d ? "R3 first read fault" : "R2 first write fault", 1'b1, d[0], fa, 0, '0);
                step("R4 second fault", 1'b1, ~d[0], fa ^ 32'hFFFF_F000, 0, '0);
                step("R7 stat read", 1'b0, 1'b0, '0, 2, '0);
                step("R9 no raise on read", 1'b0, 1'b0, '0, 4, '0);
                step("R4 third fault", 1'b1, d[0], ~fa, 0, '0);
                step("R7 addr read", 1'b0, 1'b0, '0, 4, '0);
            end
        end

        // R5 R6: data patterns through both write paths
        for (int p = 0; p < 8; p++) begin
            logic [31:0] wd;
            wd = 32'hA5A5_5A5A ^ (32'h1111_1111 * p) ^ {p[7:0], 24'h0};
            step("R2 raise", 1'b1, p[0], wd, 0, '0);
            step("R5 stat write", 1'b0, 1'b0, '0, 1, wd);
            step("R2 raise", 1'b1, p[1], ~wd, 0, '0);
            step("R6 addr write", 1'b0, 1'b0, '0, 3, ~wd);
        end
        step("R5 all ones", 1'b0, 1'b0, '0, 1, 32'hFFFF_FFFF);
        step("R5 zero", 1'b0, 1'b0, '0, 1, 32'h0);

        // R8: fault collides with every access kind, both error-flag states
        for (int k = 1; k <= 4; k++) begin
            for (int e = 0; e < 2; e++) begin
                step("R5 setup", 1'b0, 1'b0, '0, 1, e ? 32'h8000_0000 : 32'h0);
                step("R8 collision", 1'b1, k[0], 32'hCAFE_0000 + 32'(k * 32'h123), k, 32'h1234_5678);
                step("R7 drop", 1'b0, 1'b0, '0, 2, '0);
            end
        end

        // R9: accesses with irq low never raise it
        for (int k = 1; k <= 4; k++)
            step("R9 quiet access", 1'b0, 1'b0, '0, k, 32'h0F0F_0F0F);
        step("R9 idle", 1'b0, 1'b0, '0, 0, '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule